// File: doc/BRIEF.md
# Receive System-Side Frame Pulse Generator

This block sits behind a receive framer that runs as clock master. It follows the bit position of a received T1 (193-bit frame) or E1 (256-bit frame, 32 eight-bit timeslots) stream, one bit for each enabled system clock cycle. From that position it drives a frame pulse toward the system side. A position select picks what the pulse marks. In T1 mode it can mark F-bits or SF/ESF multiframe starts. In E1 mode it can mark basic frame starts, CRC or signaling multiframe starts, or the TS1 and TS16 overhead slots. A polarity input sets whether the pulse is active high or active low.

The system clock may be gapped, and a clock-enable input stands for the gaps. The upstream framer supplies alignment requests. These reload the multiframe counters so that the frame that follows the request becomes frame 0. The bit, timeslot and frame counters are also brought out as outputs.

Top module: `rx_fpulse_gen`

## Requirements
- R1: After reset, bit_pos, ts_num, frm_num and sig_num are all 0.
- R2: The counters change only on cycles where clk_en is 1. When clk_en is 0, every counter holds its value.
- R3: In T1 mode (e1_mode=0), bit_pos counts 0 to 192 and then wraps to 0. frm_num counts frames 0 to 23 and then wraps. ts_num is 0 while bit_pos is 0 (the F-bit), and (bit_pos-1)/8 otherwise.
- R4: In E1 mode (e1_mode=1), bit_pos counts 0 to 255 and ts_num equals bit_pos/8. frm_num (CRC multiframe) and sig_num (signaling multiframe) each count frames 0 to 15 and advance when bit_pos wraps.
- R5: In T1 mode the pulse is active only at bit_pos 0, under these conditions by pos_sel: 0 for every frame; 1 when frm_num is even; 2 when frm_num is 0 or 12 (SF multiframe); 3 when frm_num is 0 (ESF multiframe); 4 when frm_num is 0 (every second SF multiframe).
- R6: In E1 mode the pulse is active only at bit_pos 0, under these conditions by pos_sel: 0 for every frame; 1 when frm_num is 0; 2 when sig_num is 0; 3 when either frm_num or sig_num is 0.
- R7: In E1 mode with pos_sel=4, the pulse is active for all 8 bits of timeslot 1 and of timeslot 16, and inactive everywhere else.
- R8: The pos_sel codes 5, 6 and 7 never make the pulse active, in either mode.
- R9: With pol_inv=0, fpulse is 1 when the pulse is active. With pol_inv=1, fpulse is 0 when the pulse is active. The pulse follows the counters in the same cycle.
- R10: If mf_align is 1 on an enabled cycle, frm_num is 0 in the next frame and then counts on from there. If sig_align is 1 on an enabled cycle in E1 mode, the same holds for sig_num. In T1 mode sig_num stays 0 and sig_align has no effect.
- R11: An alignment request given on the enabled cycle where bit_pos wraps takes effect at that wrap. A request given while clk_en is 0 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_en | input | 1 | Enable for bit advance (models gapped clock) |
| e1_mode | input | 1 | 1 selects E1 framing, 0 selects T1 framing |
| pos_sel | input | 3 | Pulse position select |
| pol_inv | input | 1 | 1 makes the pulse active low |
| mf_align | input | 1 | T1 multiframe or E1 CRC multiframe alignment request |
| sig_align | input | 1 | E1 signaling multiframe alignment request |
| fpulse | output | 1 | Frame pulse toward the system side |
| bit_pos | output | 8 | Bit position within the frame |
| ts_num | output | 5 | Timeslot number |
| frm_num | output | 5 | T1 frame or E1 CRC frame number |
| sig_num | output | 4 | E1 signaling frame number |

## Verification
An alignment request can arrive on the same cycle as a frame wrap, and it can also arrive during a clock gap. Both cases are produced on purpose. In the first, mf_align is raised exactly while bit_pos is 255, and the check confirms that frm_num reads 0 at the next bit 0 while sig_num simply increments. In the second, the request comes while clk_en is low, and the check confirms that the following frame number just increments.

// File: rtl/rx_fpulse_gen.sv
module rx_fpulse_gen #(
  parameter int T1_BITS = 193,
  parameter int E1_BITS = 256,
  parameter int T1_MF   = 24,
  parameter int E1_MF   = 16,
  parameter int TS_BITS = 8
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               clk_en,
  input  logic                               e1_mode,
  input  logic [2:0]                         pos_sel,
  input  logic                               pol_inv,
  input  logic                               mf_align,
  input  logic                               sig_align,
  output logic                               fpulse,
  output logic [$clog2(E1_BITS)-1:0]         bit_pos,
  output logic [$clog2(E1_BITS/TS_BITS)-1:0] ts_num,
  output logic [$clog2(T1_MF)-1:0]           frm_num,
  output logic [$clog2(E1_MF)-1:0]           sig_num
);
  localparam int BW = $clog2(E1_BITS);
  localparam int TW = $clog2(E1_BITS/TS_BITS);
  localparam int FW = $clog2(T1_MF);
  localparam int SW = $clog2(E1_MF);
  localparam int E1_SLOTS = E1_BITS / TS_BITS;

  logic [BW-1:0] bit_q;
  logic [FW-1:0] frm_q;
  logic [SW-1:0] sig_q;
  logic          mf_pend, sig_pend;

  logic wrap, frm_last, sig_last, mf_hit, sig_hit, first_bit, act, t1_act, e1_act;
  logic [TW-1:0] t1_ts, e1_ts;

  assign wrap     = e1_mode ? (bit_q >= BW'(E1_BITS-1)) : (bit_q >= BW'(T1_BITS-1));
  assign frm_last = e1_mode ? (frm_q >= FW'(E1_MF-1))   : (frm_q >= FW'(T1_MF-1));
  assign sig_last = (sig_q == SW'(E1_MF-1));
  assign mf_hit   = mf_align | mf_pend;
  assign sig_hit  = sig_align | sig_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q    <= '0;
      frm_q    <= '0;
      sig_q    <= '0;
      mf_pend  <= 1'b0;
      sig_pend <= 1'b0;
    end else if (clk_en) begin
      if (wrap) begin
        bit_q    <= '0;
        frm_q    <= (mf_hit || frm_last) ? '0 : frm_q + FW'(1);
        sig_q    <= (!e1_mode || sig_hit || sig_last) ? '0 : sig_q + SW'(1);
        mf_pend  <= 1'b0;
        sig_pend <= 1'b0;
      end else begin
        bit_q    <= bit_q + BW'(1);
        mf_pend  <= mf_hit;
        sig_pend <= e1_mode & sig_hit;
        if (!e1_mode) sig_q <= '0;
      end
    end
  end

  assign e1_ts = TW'(bit_q / TS_BITS);
  assign t1_ts = (bit_q == '0) ? '0 : TW'((bit_q - BW'(1)) / TS_BITS);
  assign first_bit = (bit_q == '0);

  always_comb begin
    case (pos_sel)
      3'd0:    t1_act = first_bit;
      3'd1:    t1_act = first_bit & ~frm_q[0];
      3'd2:    t1_act = first_bit & ((frm_q == '0) || (frm_q == FW'(T1_MF/2)));
      3'd3,
      3'd4:    t1_act = first_bit & (frm_q == '0);
      default: t1_act = 1'b0;
    endcase
  end

  always_comb begin
    case (pos_sel)
      3'd0:    e1_act = first_bit;
      3'd1:    e1_act = first_bit & (frm_q == '0);
      3'd2:    e1_act = first_bit & (sig_q == '0);
      3'd3:    e1_act = first_bit & ((frm_q == '0) || (sig_q == '0));
      3'd4:    e1_act = (e1_ts == TW'(1)) || (e1_ts == TW'(E1_SLOTS/2));
      default: e1_act = 1'b0;
    endcase
  end

  assign act     = e1_mode ? e1_act : t1_act;
  assign fpulse  = act ^ pol_inv;
  assign bit_pos = bit_q;
  assign ts_num  = e1_mode ? e1_ts : t1_ts;
  assign frm_num = frm_q;
  assign sig_num = sig_q;
endmodule

module rx_fpulse_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       clk_en,
  input logic       e1_mode,
  input logic [2:0] pos_sel,
  input logic       pol_inv,
  input logic       mf_align,
  input logic       fpulse,
  input logic [7:0] bit_pos,
  input logic [4:0] ts_num,
  input logic [4:0] frm_num,
  input logic [3:0] sig_num
);
  // R2
  hold_when_gapped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |=> ($stable(bit_pos) && $stable(frm_num) && $stable(sig_num)));

  // R3
  t1_bit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && !e1_mode) |=> (bit_pos <= 8'd192));

  // R4
  e1_bit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && e1_mode) |=> (bit_pos == $past(bit_pos) + 8'd1));

  // R7
  ts_overhead_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (e1_mode && pos_sel == 3'd4 && (ts_num == 5'd1 || ts_num == 5'd16)) |-> (fpulse != pol_inv));

  // R8
  unused_code_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pos_sel > 3'd4) |-> (fpulse == pol_inv));

  // R10
  t1_sig_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && !e1_mode) |=> (sig_num == 4'd0));

  // R11
  align_on_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && e1_mode && mf_align && bit_pos == 8'd255) |=> (frm_num == 5'd0));
endmodule

bind rx_fpulse_gen rx_fpulse_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .e1_mode(e1_mode), .pos_sel(pos_sel),
  .pol_inv(pol_inv), .mf_align(mf_align), .fpulse(fpulse), .bit_pos(bit_pos),
  .ts_num(ts_num), .frm_num(frm_num), .sig_num(sig_num)
);

// File: tb/rx_fpulse_gen_tb.sv
module rx_fpulse_gen_tb;
  localparam int CLK_P = 10;

  logic clk, rst_n, clk_en, e1_mode, pol_inv, mf_align, sig_align;
  logic [2:0] pos_sel;
  logic fpulse;
  logic [7:0] bit_pos;
  logic [4:0] ts_num, frm_num;
  logic [3:0] sig_num;
  int checks = 0, errors = 0;

  rx_fpulse_gen u_dut (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .e1_mode(e1_mode), .pos_sel(pos_sel),
    .pol_inv(pol_inv), .mf_align(mf_align), .sig_align(sig_align), .fpulse(fpulse),
    .bit_pos(bit_pos), .ts_num(ts_num), .frm_num(frm_num), .sig_num(sig_num)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cp(input logic [2:0] s, input logic e, input string tag);
    pos_sel = s;
    #1;
    chk(tag, int'(fpulse), int'(e));
  endtask

  task automatic reset_dut(input logic e1);
    e1_mode = e1; rst_n = 1'b0; clk_en = 1'b1;
    mf_align = 1'b0; sig_align = 1'b0; pol_inv = 1'b0; pos_sel = 3'd0;
    run(2);
    rst_n = 1'b1;
  endtask

  task automatic t_reset;
    reset_dut(1'b0);
    chk("R1 bit_pos", bit_pos, 0);
    chk("R1 ts_num", ts_num, 0);
    chk("R1 frm_num", frm_num, 0);
    chk("R1 sig_num", sig_num, 0);
    cp(3'd0, 1'b1, "R5 sel0 at reset");
  endtask

  task automatic t_gap;
    reset_dut(1'b0);
    clk_en = 1'b0;
    run(5);
    chk("R2 held during gap", bit_pos, 0);
    clk_en = 1'b1;
    run(5);
    chk("R2 advance after gap", bit_pos, 5);
    chk("R3 ts at bit5", ts_num, 0);
    run(4);
    chk("R3 ts at bit9", ts_num, 1);
  endtask

  task automatic t_t1_count;
    reset_dut(1'b0);
    run(192);
    chk("R3 last bit", bit_pos, 192);
    chk("R3 ts at bit192", ts_num, 23);
    cp(3'd0, 1'b0, "R5 sel0 off F-bit");
    run(1);
    chk("R3 wrap bit", bit_pos, 0);
    chk("R3 frame 1", frm_num, 1);
    cp(3'd0, 1'b1, "R5 sel0 frm1");
    cp(3'd1, 1'b0, "R5 sel1 frm1");
    cp(3'd2, 1'b0, "R5 sel2 frm1");
    cp(3'd3, 1'b0, "R5 sel3 frm1");
    run(193);
    cp(3'd1, 1'b1, "R5 sel1 frm2");
    run(193*10);
    chk("R3 frame 12", frm_num, 12);
    cp(3'd2, 1'b1, "R5 sel2 frm12");
    cp(3'd3, 1'b0, "R5 sel3 frm12");
    cp(3'd4, 1'b0, "R5 sel4 frm12");
    run(193*12);
    chk("R3 frame wrap at 24", frm_num, 0);
    cp(3'd3, 1'b1, "R5 sel3 frm0");
    cp(3'd4, 1'b1, "R5 sel4 frm0");
    cp(3'd5, 1'b0, "R8 sel5 T1");
    run(1);
    cp(3'd0, 1'b0, "R5 sel0 bit1");
  endtask

  task automatic t_pol;
    reset_dut(1'b0);
    pol_inv = 1'b1;
    cp(3'd0, 1'b0, "R9 inverted active");
    cp(3'd6, 1'b1, "R9 inverted idle");
    run(1);
    cp(3'd0, 1'b1, "R9 inverted off bit");
    pol_inv = 1'b0;
  endtask

  task automatic t_t1_align;
    reset_dut(1'b0);
    run(193*5 + 7);
    chk("R10 T1 frame before align", frm_num, 5);
    mf_align = 1'b1; sig_align = 1'b1;
    run(1);
    mf_align = 1'b0; sig_align = 1'b0;
    chk("R10 frame kept mid-frame", frm_num, 5);
    run(185);
    chk("R10 T1 realigned", frm_num, 0);
    chk("R10 T1 sig ignored", sig_num, 0);
    run(193);
    chk("R10 T1 counts on", frm_num, 1);
  endtask

  task automatic t_e1_count;
    reset_dut(1'b1);
    cp(3'd7, 1'b0, "R8 sel7 E1");
    run(7);
    cp(3'd4, 1'b0, "R7 ts0");
    run(1);
    chk("R4 ts at bit8", ts_num, 1);
    cp(3'd4, 1'b1, "R7 ts1 start");
    run(7);
    cp(3'd4, 1'b1, "R7 ts1 end");
    run(1);
    cp(3'd4, 1'b0, "R7 ts2");
    run(112);
    chk("R4 ts at bit128", ts_num, 16);
    cp(3'd4, 1'b1, "R7 ts16");
    run(8);
    cp(3'd4, 1'b0, "R7 ts17");
    run(119);
    chk("R4 last bit", bit_pos, 255);
    chk("R4 ts31", ts_num, 31);
    run(1);
    chk("R4 crc frame 1", frm_num, 1);
    chk("R4 sig frame 1", sig_num, 1);
    cp(3'd0, 1'b1, "R6 sel0 frm1");
    cp(3'd1, 1'b0, "R6 sel1 frm1");
    cp(3'd2, 1'b0, "R6 sel2 frm1");
    cp(3'd3, 1'b0, "R6 sel3 frm1");
    run(256*15);
    chk("R4 crc wrap at 16", frm_num, 0);
    chk("R4 sig wrap at 16", sig_num, 0);
    cp(3'd1, 1'b1, "R6 sel1 frm0");
  endtask

  task automatic t_e1_align;
    reset_dut(1'b1);
    run(256*3 + 10);
    sig_align = 1'b1;
    run(1);
    sig_align = 1'b0;
    run(245);
    chk("R10 E1 bit at wrap", bit_pos, 0);
    chk("R10 crc unaffected", frm_num, 4);
    chk("R10 sig realigned", sig_num, 0);
    cp(3'd1, 1'b0, "R6 sel1 crc4");
    cp(3'd2, 1'b1, "R6 sel2 sig0");
    cp(3'd3, 1'b1, "R6 sel3 either");
    clk_en = 1'b0; mf_align = 1'b1;
    run(1);
    clk_en = 1'b1; mf_align = 1'b0;
    run(256);
    chk("R11 gap align ignored", frm_num, 5);
    run(255);
    mf_align = 1'b1;
    run(1);
    mf_align = 1'b0;
    chk("R11 align on wrap crc", frm_num, 0);
    chk("R11 align on wrap sig", sig_num, 2);
    cp(3'd1, 1'b1, "R11 sel1 after align");
  endtask

  initial begin
    t_reset();
    t_gap();
    t_t1_count();
    t_pol();
    t_t1_align();
    t_e1_count();
    t_e1_align();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule